// File: doc/BRIEF.md
# Register Rename Map with Mispredict Recovery

This block is the renaming core of an out-of-order core that keeps all register values in one physical register file. It holds two tables that map each architected register to a physical register. The speculative table is read and written at dispatch. The committed table is written at retirement. Beside the tables sits a pool that keeps a free bit and a ready (valid) bit for every physical register.

At dispatch the block returns the current physical register and ready bit for two source operands. If the instruction writes a register, the block also claims one free physical register as its destination. A completion strobe marks a physical register ready. A retire strobe moves a destination into the committed table and hands back the register that the table held before. A flush strobe, raised on a branch mispredict, rebuilds the speculative state from the committed table in one cycle.

With the default parameters there are 32 architected and 96 physical registers, so every pointer is 7 bits wide. The block has no reorder buffer. The retire and flush strobes carry the register numbers that the block needs.

Top module: `rename_map`

## Requirements
- R1: After reset, architected register i maps to physical register i in both tables. Physical registers 0 to 31 are ready and in use. Physical registers 32 to 95 are free and not ready, so the first destination handed out is 32.
- R2: A dispatch with a destination receives the lowest-numbered free physical register on `disp_dst_phys`. After the clock edge that register is in use and not ready, and the destination's speculative entry points to it.
- R3: Source lookups on `disp_src0_phys`/`disp_src1_phys` and their ready bits return the table contents from before the same cycle's destination update. An instruction that reads and writes the same register therefore sees the old mapping.
- R4: `disp_ready` is low when `disp_has_dst` is 1 and no physical register is free. A request that is not accepted changes no table. A dispatch with `disp_has_dst` at 0 stays ready even when the pool is empty.
- R5: A completion strobe with a physical register number makes that register read back as ready from the next cycle on.
- R6: A retire strobe writes `ret_phys` into the committed entry for `ret_arch`. The physical register that entry held before becomes free and not ready, so it can be handed out again.
- R7: A flush copies the whole committed table into the speculative table in one cycle.
- R8: A flush makes every physical register that the committed table does not reference free and not ready. While `flush` is high, `disp_ready` is low and no dispatch takes effect.
- R9: When a retire and a flush fall in the same cycle, the rebuild uses the committed table that already includes that retire.
- R10: A free physical register is never ready. A register that has been freed and then handed out again reads back as not ready until its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_req | input | 1 | Dispatch request this cycle |
| disp_has_dst | input | 1 | Dispatching instruction writes a register |
| disp_dst_arch | input | 5 | Destination architected register |
| disp_src0_arch | input | 5 | First source architected register |
| disp_src1_arch | input | 5 | Second source architected register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_dst_phys | output | 7 | Physical register granted to the destination |
| disp_src0_phys | output | 7 | Current mapping of the first source |
| disp_src0_valid | output | 1 | First source value is ready |
| disp_src1_phys | output | 7 | Current mapping of the second source |
| disp_src1_valid | output | 1 | Second source value is ready |
| cpl_en | input | 1 | Completion strobe |
| cpl_phys | input | 7 | Physical register whose value was written |
| ret_en | input | 1 | Retire strobe |
| ret_arch | input | 5 | Architected destination of the retiring instruction |
| ret_phys | input | 7 | Physical destination of the retiring instruction |
| flush | input | 1 | Branch mispredict recovery strobe |

## Verification
The bench targets these corner cases:

- **Read before write.** An instruction reads and writes the same register. A design that forwarded the new mapping to the sources would hand back the fresh register and create a false dependence.
- **Reuse of a freed register.** A register freed by retirement is reused at once. A design that left it marked ready would let a consumer read a stale value.
- **Empty pool.** The free pool is drained completely. A design that ignored the stall would overwrite a mapping or hand out a live register.
- **Flush races.** A flush arrives while a dispatch is requested, and later in the same cycle as a retire. A design that let the dispatch through, or rebuilt from the committed table before the retire, would leak or double-free a register.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int NUM_ARCH = 32;
  parameter int NUM_PHYS = 96;
  localparam int ARCH_W = $clog2(NUM_ARCH);
  localparam int PTR_W  = $clog2(NUM_PHYS);

  typedef logic [ARCH_W-1:0]   arch_t;
  typedef logic [PTR_W-1:0]    phys_t;
  typedef logic [NUM_PHYS-1:0] pvec_t;
  typedef phys_t [NUM_ARCH-1:0] map_t;

  // Reset mapping: architected register i sits in physical register i.
  function automatic map_t identity_map();
    map_t m;
    for (int i = 0; i < NUM_ARCH; i++) m[i] = phys_t'(i);
    return m;
  endfunction

  // One bit per physical register that some entry of the map points at.
  function automatic pvec_t map_refs(map_t m);
    pvec_t r = '0;
    for (int i = 0; i < NUM_ARCH; i++) r[m[i]] = 1'b1;
    return r;
  endfunction

  // Lowest-numbered set bit; 0 when the vector is empty.
  function automatic phys_t lowest_set(pvec_t v);
    phys_t r = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) if (v[i]) r = phys_t'(i);
    return r;
  endfunction

  // Physical registers owned by the architected state at reset.
  function automatic pvec_t reset_owned();
    pvec_t r = '0;
    for (int i = 0; i < NUM_ARCH; i++) r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rn_spec_map.sv
module rn_spec_map
  import rn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  arch_t wr_arch,
  input  phys_t wr_phys,
  input  logic  restore,
  input  map_t  restore_map,
  output map_t  map_q
);
  map_t init_map;
  assign init_map = identity_map();

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[g] <= init_map[g];
      else if (restore)
        map_q[g] <= restore_map[g];
      else if (wr_en && wr_arch == arch_t'(g))
        map_q[g] <= wr_phys;
    end
  end
endmodule

// File: rtl/rn_retire_map.sv
module rn_retire_map
  import rn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  arch_t upd_arch,
  input  phys_t upd_phys,
  output map_t  map_q,
  output map_t  map_next,
  output phys_t prev_phys
);
  assign prev_phys = map_q[upd_arch];

  always_comb begin
    map_next = map_q;
    if (upd_en) map_next[upd_arch] = upd_phys;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= identity_map();
    else        map_q <= map_next;
  end
endmodule

// File: rtl/rn_phys_pool.sv
module rn_phys_pool
  import rn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_en,
  input  logic  cpl_en,
  input  phys_t cpl_phys,
  input  logic  rel_en,
  input  phys_t rel_phys,
  input  logic  rebuild,
  input  pvec_t keep,
  output pvec_t free_q,
  output pvec_t valid_q,
  output phys_t alloc_phys,
  output logic  any_free
);
  pvec_t free_n, valid_n;

  assign alloc_phys = lowest_set(free_q);
  assign any_free   = |free_q;

  // Order inside a cycle: completion, release, claim, then flush rebuild.
  always_comb begin
    free_n  = free_q;
    valid_n = valid_q;
    if (cpl_en) valid_n[cpl_phys] = 1'b1;
    if (rel_en) begin
      free_n[rel_phys]  = 1'b1;
      valid_n[rel_phys] = 1'b0;
    end
    if (alloc_en) begin
      free_n[alloc_phys]  = 1'b0;
      valid_n[alloc_phys] = 1'b0;
    end
    if (rebuild) begin
      free_n  = ~keep;
      valid_n = valid_n & keep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q  <= ~reset_owned();
      valid_q <= reset_owned();
    end else begin
      free_q  <= free_n;
      valid_q <= valid_n;
    end
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_req,
  input  logic              disp_has_dst,
  input  logic [ARCH_W-1:0] disp_dst_arch,
  input  logic [ARCH_W-1:0] disp_src0_arch,
  input  logic [ARCH_W-1:0] disp_src1_arch,
  output logic              disp_ready,
  output logic [PTR_W-1:0]  disp_dst_phys,
  output logic [PTR_W-1:0]  disp_src0_phys,
  output logic              disp_src0_valid,
  output logic [PTR_W-1:0]  disp_src1_phys,
  output logic              disp_src1_valid,
  input  logic              cpl_en,
  input  logic [PTR_W-1:0]  cpl_phys,
  input  logic              ret_en,
  input  logic [ARCH_W-1:0] ret_arch,
  input  logic [PTR_W-1:0]  ret_phys,
  input  logic              flush
);
  // Named internal events, visible to the bound checker.
  logic  disp_fire;
  logic  alloc_fire;
  logic  any_free;
  phys_t rel_phys;
  phys_t alloc_phys;
  map_t  spec_q;
  map_t  rrat_q;
  map_t  rrat_next;
  pvec_t keep_vec;
  pvec_t free_q;
  pvec_t valid_q;

  assign disp_ready = !flush && (!disp_has_dst || any_free);
  assign disp_fire  = disp_req && disp_ready;
  assign alloc_fire = disp_fire && disp_has_dst;
  assign keep_vec   = map_refs(rrat_next);

  assign disp_dst_phys   = alloc_phys;
  assign disp_src0_phys  = spec_q[disp_src0_arch];
  assign disp_src1_phys  = spec_q[disp_src1_arch];
  assign disp_src0_valid = valid_q[disp_src0_phys];
  assign disp_src1_valid = valid_q[disp_src1_phys];

  rn_spec_map u_spec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (alloc_fire),
    .wr_arch    (disp_dst_arch),
    .wr_phys    (alloc_phys),
    .restore    (flush),
    .restore_map(rrat_next),
    .map_q      (spec_q)
  );

  rn_retire_map u_retire (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (ret_en),
    .upd_arch (ret_arch),
    .upd_phys (ret_phys),
    .map_q    (rrat_q),
    .map_next (rrat_next),
    .prev_phys(rel_phys)
  );

  rn_phys_pool u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_fire),
    .cpl_en    (cpl_en),
    .cpl_phys  (cpl_phys),
    .rel_en    (ret_en),
    .rel_phys  (rel_phys),
    .rebuild   (flush),
    .keep      (keep_vec),
    .free_q    (free_q),
    .valid_q   (valid_q),
    .alloc_phys(alloc_phys),
    .any_free  (any_free)
  );
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk
  import rn_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  flush,
  input logic  disp_has_dst,
  input logic  disp_ready,
  input logic  alloc_fire,
  input phys_t disp_dst_phys,
  input logic  ret_en,
  input phys_t rel_phys,
  input pvec_t free_q,
  input pvec_t valid_q
);
  AST_FREE_NEVER_VALID: assert property (@(posedge clk) disable iff (!rst_n) (free_q & valid_q) == '0); // R10
  AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (disp_has_dst && free_q == '0) |-> !disp_ready); // R4
  AST_FLUSH_HOLDS_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n) flush |-> !disp_ready); // R8
  AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n) alloc_fire |-> free_q[disp_dst_phys]); // R2
  AST_ALLOC_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n) alloc_fire |=> (!free_q[$past(disp_dst_phys)] && !valid_q[$past(disp_dst_phys)])); // R2
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n) (ret_en && !flush) |=> free_q[$past(rel_phys)]); // R6
  AST_FLUSH_POOL_SIZE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> ($countones(free_q) >= NUM_PHYS - NUM_ARCH)); // R8
endmodule

bind rename_map rename_map_chk u_rename_map_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .disp_has_dst (disp_has_dst),
  .disp_ready   (disp_ready),
  .alloc_fire   (alloc_fire),
  .disp_dst_phys(disp_dst_phys),
  .ret_en       (ret_en),
  .rel_phys     (rel_phys),
  .free_q       (free_q),
  .valid_q      (valid_q)
);

// File: tb/rename_map_bench.sv
`timescale 1ns/1ps
module rename_map_bench;
  import rn_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_req = 0, disp_has_dst = 0;
  logic [ARCH_W-1:0] disp_dst_arch = '0, disp_src0_arch = '0, disp_src1_arch = '0;
  logic disp_ready, disp_src0_valid, disp_src1_valid;
  logic [PTR_W-1:0] disp_dst_phys, disp_src0_phys, disp_src1_phys;
  logic cpl_en = 0, ret_en = 0, flush = 0;
  logic [PTR_W-1:0] cpl_phys = '0, ret_phys = '0;
  logic [ARCH_W-1:0] ret_arch = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rename_map u_rename_map (.*);

  localparam logic [1:0] OP_D = 2'd0, OP_C = 2'd1, OP_R = 2'd2, OP_F = 2'd3;
  typedef struct packed {
    logic [1:0] op;
    logic [4:0] dst;
    logic [4:0] src;
    logic [6:0] phys;
    logic [6:0] e_dst;
    logic [6:0] e_src;
    logic       e_v;
  } vec_t;

  // op, dst arch / retire arch, src arch, phys, expected dst, expected src, expected src ready
  localparam vec_t VECS [13] = '{
    '{OP_D, 5'd3, 5'd3, 7'd0,  7'd32, 7'd3,  1'b1},
    '{OP_D, 5'd5, 5'd3, 7'd0,  7'd33, 7'd32, 1'b0},
    '{OP_C, 5'd0, 5'd0, 7'd32, 7'd0,  7'd0,  1'b0},
    '{OP_D, 5'd7, 5'd3, 7'd0,  7'd34, 7'd32, 1'b1},
    '{OP_R, 5'd3, 5'd0, 7'd32, 7'd0,  7'd0,  1'b0},
    '{OP_D, 5'd3, 5'd5, 7'd0,  7'd3,  7'd33, 1'b0},
    '{OP_D, 5'd1, 5'd7, 7'd0,  7'd35, 7'd34, 1'b0},
    '{OP_F, 5'd0, 5'd0, 7'd0,  7'd0,  7'd0,  1'b0},
    '{OP_D, 5'd9, 5'd3, 7'd0,  7'd3,  7'd32, 1'b1},
    '{OP_D, 5'd0, 5'd9, 7'd0,  7'd33, 7'd3,  1'b0},
    '{OP_D, 5'd2, 5'd1, 7'd0,  7'd34, 7'd1,  1'b1},
    '{OP_C, 5'd0, 5'd0, 7'd3,  7'd0,  7'd0,  1'b0},
    '{OP_D, 5'd4, 5'd9, 7'd0,  7'd35, 7'd3,  1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    disp_req = 0; disp_has_dst = 0; cpl_en = 0; ret_en = 0; flush = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    disp_src0_arch = 5'd17; disp_src1_arch = 5'd31; disp_has_dst = 1;
    #1;
    chk("R1 src0 phys", disp_src0_phys, 17);
    chk("R1 src0 ready", disp_src0_valid, 1);
    chk("R1 src1 phys", disp_src1_phys, 31);
    chk("R1 src1 ready", disp_src1_valid, 1);
    chk("R1 first dst", disp_dst_phys, 32);
    chk("R1 ready", disp_ready, 1);
    disp_has_dst = 0;

    // Vector table: R2 R3 R5 R6 R7 R8 R10
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      idle();
      case (VECS[i].op)
        OP_D: begin
          disp_req = 1; disp_has_dst = 1;
          disp_dst_arch = VECS[i].dst; disp_src0_arch = VECS[i].src;
        end
        OP_C: begin cpl_en = 1; cpl_phys = VECS[i].phys; end
        OP_R: begin ret_en = 1; ret_arch = VECS[i].dst; ret_phys = VECS[i].phys; end
        default: flush = 1;
      endcase
      #1;
      if (VECS[i].op == OP_D) begin
        chk($sformatf("R2 vec%0d dst", i), disp_dst_phys, VECS[i].e_dst);
        chk($sformatf("R3 vec%0d src", i), disp_src0_phys, VECS[i].e_src);
        chk($sformatf("R5/R10 vec%0d src ready", i), disp_src0_valid, VECS[i].e_v);
        chk($sformatf("R4 vec%0d ready", i), disp_ready, 1);
      end
      @(posedge clk);
    end

    // R2 and R4: drain the pool (36..95) into arch 10
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      idle();
      disp_req = 1; disp_has_dst = 1; disp_dst_arch = 5'd10;
      #1;
      chk("R2 drain dst", disp_dst_phys, 36 + k);
      @(posedge clk);
    end
    @(negedge clk);
    idle();
    disp_req = 1; disp_has_dst = 1; disp_dst_arch = 5'd10;
    #1;
    chk("R4 empty stall", disp_ready, 0);
    @(posedge clk);
    @(negedge clk);
    disp_dst_arch = 5'd0;
    #1;
    chk("R4 still stalled", disp_ready, 0);
    @(posedge clk);
    @(negedge clk);
    idle();
    disp_req = 1; disp_has_dst = 0; disp_src0_arch = 5'd10; disp_src1_arch = 5'd0;
    #1;
    chk("R4 no dst ready when empty", disp_ready, 1);
    chk("R4 stalled write dropped arch10", disp_src0_phys, 95);
    chk("R4 stalled write dropped arch0", disp_src1_phys, 33);

    // R8: flush blocks a dispatch in the same cycle
    @(negedge clk);
    idle();
    flush = 1; disp_req = 1; disp_has_dst = 1; disp_dst_arch = 5'd10;
    #1;
    chk("R8 flush blocks dispatch", disp_ready, 0);
    @(posedge clk);
    @(negedge clk);
    idle();
    disp_src0_arch = 5'd10; disp_src1_arch = 5'd3; disp_has_dst = 1;
    #1;
    chk("R7 arch10 restored", disp_src0_phys, 10);
    chk("R7 arch3 restored", disp_src1_phys, 32);
    chk("R7 arch3 ready", disp_src1_valid, 1);
    chk("R8 lowest free after flush", disp_dst_phys, 3);
    chk("R8 ready after flush", disp_ready, 1);

    // R9: retire and flush together
    @(negedge clk);
    idle();
    disp_req = 1; disp_has_dst = 1; disp_dst_arch = 5'd9;
    #1;
    chk("R8 dst after flush", disp_dst_phys, 3);
    @(posedge clk);
    @(negedge clk);
    idle();
    cpl_en = 1; cpl_phys = 7'd3;
    @(posedge clk);
    @(negedge clk);
    idle();
    ret_en = 1; ret_arch = 5'd9; ret_phys = 7'd3; flush = 1;
    @(posedge clk);
    @(negedge clk);
    idle();
    disp_src0_arch = 5'd9; disp_src1_arch = 5'd3; disp_has_dst = 1;
    #1;
    chk("R9 arch9 keeps retired phys", disp_src0_phys, 3);
    chk("R9 arch9 ready", disp_src0_valid, 1);
    chk("R9 arch3 phys", disp_src1_phys, 32);
    chk("R9 old phys freed", disp_dst_phys, 9);
    chk("R9 ready", disp_ready, 1);

    done = 1;
    idle();
    @(posedge clk);
    finish_run();
  end
endmodule